// File: doc/BRIEF.md
# I2C Target Acknowledge and Clock-Stretch Controller

This block is the acknowledge and wait-state logic of an I2C target. It synchronizes the SCL and SDA pins to the system clock and finds START and STOP conditions. It assembles each received byte and checks the first byte after a START against a programmed 7-bit local address. The block then decides whether to pull SDA low in the ninth SCL clock. In read transfers, where it is the transmitter, it records whether the controller acknowledged the byte.

Software controls the block through a few static inputs. One input enables acknowledgement of data and extension codes. Another places the wait point after the eighth clock or after the ninth clock. A third input holds the local address, and a one-cycle strobe ends a wait. At each wait point of an addressed transfer the block holds SCL low and gives a one-cycle interrupt pulse. The pin outputs are open-drain pull requests, where 1 means drive the line low. The data bits of a read transfer come from outside this block.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: After reset, scl_pull, sda_pull, wait_irq, xmit_mode, addr_selected and peer_acked are all 0.
- R2: The first byte after a START is an address byte: bits 7..1 (MSB first on the wire) are the address and bit 0 is the direction. If the address equals own_addr, the block pulls SDA low in the ninth clock whatever ack_en is, and addr_selected becomes 1.
- R3: An address that neither matches own_addr nor is an extension code gets no acknowledge and no wait. Every byte after it gets no acknowledge and no wait until the next START.
- R4: After an address byte, xmit_mode equals its direction bit: 1 means the target transmits and 0 means it receives.
- R5: An address whose top four bits are all 1 is an extension code. It is acknowledged only when ack_en is 1 at the point the acknowledge is decided, and it selects the block for the rest of the transfer.
- R6: In a selected write transfer, a data byte is acknowledged only when ack_en is 1.
- R7: With wait_after9 = 0, the block holds SCL low after the falling edge of the eighth clock of each selected byte and gives one wait_irq pulse. The value of ack_en when wait_release arrives decides the acknowledge, and the strobe frees SCL.
- R8: With wait_after9 = 1, the block holds SCL low after the falling edge of the ninth clock of each selected byte and gives one wait_irq pulse. The acknowledge follows the value ack_en had at the end of the eighth clock.
- R9: In a selected read transfer the block never pulls SDA on its own ninth clocks. peer_acked records whether SDA was low at the rising edge of the ninth clock.
- R10: The block releases SDA once the ninth clock falls.
- R11: A STOP releases SCL and SDA and clears addr_selected. A START also clears addr_selected, and the next byte is then read as an address.
- R12: rx_byte holds the last eight bits sampled on rising SCL edges, first bit in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_pull | output | 1 | 1 = drive SCL low (wait state) |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| ack_en | input | 1 | Acknowledge enable for data and extension codes |
| wait_after9 | input | 1 | 0 = wait after eighth clock, 1 = after ninth clock |
| own_addr | input | 7 | Local target address |
| wait_release | input | 1 | One-cycle strobe that ends a wait |
| wait_irq | output | 1 | One-cycle pulse at each wait point |
| xmit_mode | output | 1 | Direction flag of the current transfer |
| addr_selected | output | 1 | Transfer is addressed to this target |
| peer_acked | output | 1 | Controller acknowledged the last transmitted byte |
| rx_byte | output | 8 | Last assembled byte |

## Verification
The assertions assume that SDA changes only while SCL is low, except for START and STOP. They also assume that each SCL phase lasts longer than the synchronizer latency, and that no START or STOP arrives while the block is holding SCL low. The stimulus keeps to these assumptions. The bench controller changes SDA only two or more system cycles after SCL falls, uses eight-cycle SCL phases, and gives a wait_release strobe only at the wait points that the reference model predicts.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

  // Bus events seen on the synchronized lines, one cycle each.
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

  // Top nibble of an extension-code address.
  localparam logic [3:0] EXT_MARK = 4'hF;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d};

  // Idle bus level is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_ack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.rise  = scl_s & ~scl_q;
    evt.fall  = ~scl_s & scl_q;
    evt.start = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_byte_track.sv
module i2c_byte_track
  import i2c_ack_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_evt_t      evt,
  input  logic          sda_s,
  input  logic [AW-1:0] own_addr,
  output logic [AW:0]   rx_byte,
  output logic          end8,
  output logic          end9,
  output logic          is_addr,
  output logic          addr_hit,
  output logic          addr_ext,
  output logic          engaged,
  output logic          sel,
  output logic          dir,
  output logic          peer_ack,
  output logic          ack_window
);
  localparam int LAST = AW + 1;              // data bits per byte
  localparam int CW   = $clog2(LAST + 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW:0]   sh_q, sh_d;
  logic          addr_q, addr_d, sel_q, sel_d, dir_q, dir_d, seen_q, seen_d;

  assign addr_hit = addr_q && (sh_q[AW:1] == own_addr);
  assign addr_ext = addr_q && (sh_q[AW:AW-3] == EXT_MARK);
  assign engaged  = addr_q ? (addr_hit | addr_ext) : sel_q;
  assign end8     = evt.fall && (cnt_q == CW'(LAST));
  assign end9     = evt.fall && (cnt_q == CW'(LAST + 1));

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    addr_d = addr_q;
    sel_d  = sel_q;
    dir_d  = dir_q;
    seen_d = seen_q;
    if (evt.stop) begin
      cnt_d  = '0;
      addr_d = 1'b0;
      sel_d  = 1'b0;
    end else if (evt.start) begin
      cnt_d  = '0;
      addr_d = 1'b1;
      sel_d  = 1'b0;
      seen_d = 1'b0;
    end else if (evt.rise) begin
      if (cnt_q < CW'(LAST)) begin
        sh_d  = {sh_q[AW-1:0], sda_s};
        cnt_d = cnt_q + 1'b1;
      end else if (cnt_q == CW'(LAST)) begin
        cnt_d = CW'(LAST + 1);
        if (sel_q && dir_q && !addr_q) seen_d = ~sda_s;
      end
    end else if (end8 && addr_q) begin
      sel_d = addr_hit | addr_ext;
      dir_d = sh_q[0];
    end else if (end9) begin
      cnt_d  = '0;
      addr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= 1'b0;
      sel_q  <= 1'b0;
      dir_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      sel_q  <= sel_d;
      dir_q  <= dir_d;
      seen_q <= seen_d;
    end
  end

  assign rx_byte    = sh_q;
  assign is_addr    = addr_q;
  assign sel        = sel_q;
  assign dir        = dir_q;
  assign peer_ack   = seen_q;
  assign ack_window = (cnt_q >= CW'(LAST));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST + 1)); // R12
  AST_SEL_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(addr_q)); // R3
endmodule

// File: rtl/i2c_ack_wait.sv
module i2c_ack_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic end8,
  input  logic end9,
  input  logic is_addr,
  input  logic addr_hit,
  input  logic addr_ext,
  input  logic engaged,
  input  logic sel,
  input  logic dir,
  input  logic ack_window,
  input  logic ack_en,
  input  logic wait9,
  input  logic release_i,
  output logic sda_pull,
  output logic scl_hold,
  output logic irq
);
  logic hold_q, hold_d, h8_q, h8_d, pull_q, pull_d, irq_q, irq_d;
  logic need_ack;

  // Local address is forced; extension codes and data follow ack_en.
  assign need_ack = is_addr ? (addr_hit | (addr_ext & ack_en))
                            : (sel & ~dir & ack_en);

  always_comb begin
    hold_d = hold_q;
    h8_d   = h8_q;
    pull_d = pull_q;
    irq_d  = 1'b0;
    if (bus_stop) begin
      hold_d = 1'b0;
      pull_d = 1'b0;
    end else begin
      if (bus_start) pull_d = 1'b0;
      if (end8) begin
        pull_d = need_ack;
        if (!wait9 && engaged) begin
          hold_d = 1'b1;
          h8_d   = 1'b1;
          irq_d  = 1'b1;
        end
      end else if (end9) begin
        pull_d = 1'b0;
        if (wait9 && engaged) begin
          hold_d = 1'b1;
          h8_d   = 1'b0;
          irq_d  = 1'b1;
        end
      end else if (hold_q && release_i) begin
        hold_d = 1'b0;
        if (h8_q) pull_d = need_ack;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      h8_q   <= 1'b0;
      pull_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      h8_q   <= h8_d;
      pull_q <= pull_d;
      irq_q  <= irq_d;
    end
  end

  assign sda_pull = pull_q;
  assign scl_hold = hold_q;
  assign irq      = irq_q;

  AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> ack_window); // R10
  AST_HOLD_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> engaged); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7
  AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!hold_q && !pull_q)); // R11
  AST_HIT_FORCES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (end8 && addr_hit) |=> pull_q); // R2
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (end8 && is_addr && !addr_hit && !addr_ext) |=> (!pull_q && !hold_q)); // R3
endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl
  import i2c_ack_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              ack_en,
  input  logic              wait_after9,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              wait_release,
  output logic              wait_irq,
  output logic              xmit_mode,
  output logic              addr_selected,
  output logic              peer_acked,
  output logic [ADDR_W:0]   rx_byte
);
  // Reset asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic     scl_s, sda_s;
  bus_evt_t evt;
  logic     end8, end9, is_addr, addr_hit, addr_ext, engaged, sel, dir, ack_window;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_core_n), .d(scl_in), .q(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_core_n), .d(sda_in), .q(sda_s));

  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_core_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

  i2c_byte_track #(.AW(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_core_n), .evt(evt), .sda_s(sda_s), .own_addr(own_addr),
    .rx_byte(rx_byte), .end8(end8), .end9(end9), .is_addr(is_addr),
    .addr_hit(addr_hit), .addr_ext(addr_ext), .engaged(engaged), .sel(sel),
    .dir(dir), .peer_ack(peer_acked), .ack_window(ack_window));

  i2c_ack_wait u_ackw (
    .clk(clk), .rst_n(rst_core_n), .bus_start(evt.start), .bus_stop(evt.stop),
    .end8(end8), .end9(end9), .is_addr(is_addr), .addr_hit(addr_hit),
    .addr_ext(addr_ext), .engaged(engaged), .sel(sel), .dir(dir),
    .ack_window(ack_window), .ack_en(ack_en), .wait9(wait_after9),
    .release_i(wait_release), .sda_pull(sda_pull), .scl_hold(scl_pull),
    .irq(wait_irq));

  assign xmit_mode     = dir;
  assign addr_selected = sel;
endmodule

// File: tb/i2c_ack_ctrl_test.sv
module i2c_ack_ctrl_test;
  localparam int T = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic ack_en, wait_after9, wait_release;
  logic scl_pull, sda_pull, wait_irq, xmit_mode, addr_selected, peer_acked;
  logic [7:0] rx_byte;
  wire scl_line = scl_m & ~scl_pull;
  wire sda_line = sda_m & ~sda_pull;

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0, irq_cnt = 0;
  bit mon_en = 0, hold_ok = 0, done = 0;
  bit m_first = 0, m_sel = 0, m_dir = 0;

  always #10 clk = ~clk;

  i2c_ack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .ack_en(ack_en),
    .wait_after9(wait_after9), .own_addr(OWN), .wait_release(wait_release),
    .wait_irq(wait_irq), .xmit_mode(xmit_mode), .addr_selected(addr_selected),
    .peer_acked(peer_acked), .rx_byte(rx_byte));

  // Per-clock comparison: SCL hold and interrupt only inside predicted waits.
  always @(negedge clk) begin
    if (mon_en) begin
      mon_total++;
      if (wait_irq) irq_cnt++;
      if ((scl_pull || wait_irq) && !hold_ok) begin
        mon_bad++;
        $display("FAIL R7/R8 unexpected hold actual=%0d expected=0", scl_pull | wait_irq);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_clk(input logic v);
    sda_m = v; tick(T);
    scl_m = 1'b1; tick(T);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic release_wait();
    wait_release = 1'b1; tick(1);
    wait_release = 1'b0; tick(3);
    hold_ok = 0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T);
    scl_m = 1'b0; tick(2);
    m_first = 1; m_sel = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b1; tick(T);
    m_first = 0; m_sel = 0;
    chk("R11 scl released", scl_pull, 0);
    chk("R11 sda released", sda_pull, 0);
    chk("R11 selection cleared", addr_selected, 0);
  endtask

  // One byte plus acknowledge clock; expectations come from the model.
  task automatic send(input logic [7:0] b, input bit m_ack, input bit en_rel, input string req);
    bit first, hit, ext, eng, en_eff, exp_ack, rd;
    int wpt, irq0;
    first = m_first;
    hit = first && (b[7:1] == OWN);
    ext = first && (b[7:4] == 4'hF);
    eng = first ? (hit | ext) : m_sel;
    en_eff = (!wait_after9 && eng) ? en_rel : ack_en;
    exp_ack = first ? (hit | (ext & en_eff)) : (m_sel & !m_dir & en_eff);
    rd = !first && m_sel && m_dir;
    wpt = !eng ? 0 : (wait_after9 ? 9 : 8);
    irq0 = irq_cnt;
    if (wpt == 8) hold_ok = 1;
    for (int i = 7; i >= 0; i--) bit_clk(b[i]);
    if (wpt == 8) begin
      tick(T);
      chk({req, " R7 hold after 8th"}, scl_pull, 1);
      chk({req, " R7 irq"}, irq_cnt, irq0 + 1);
      ack_en = en_rel;
      release_wait();
    end
    sda_m = m_ack ? 1'b0 : 1'b1;
    tick(T);
    scl_m = 1'b1; tick(T/2);
    chk({req, " ack"}, sda_pull, exp_ack);
    chk("R12 rx_byte", rx_byte, b);
    tick(T/2);
    if (wpt == 9) hold_ok = 1;
    scl_m = 1'b0; tick(T);
    chk("R10 sda released after 9th", sda_pull, 0);
    sda_m = 1'b1;
    if (wpt == 9) begin
      chk({req, " R8 hold after 9th"}, scl_pull, 1);
      chk({req, " R8 irq"}, irq_cnt, irq0 + 1);
      release_wait();
    end else if (wpt == 0) begin
      chk({req, " R3 no irq"}, irq_cnt, irq0);
    end
    if (rd) chk("R9 peer ack", peer_acked, m_ack);
    if (first) begin
      m_sel = eng; m_dir = b[0]; m_first = 0;
      chk("R4 direction", xmit_mode, b[0]);
      chk({req, " selected"}, addr_selected, eng);
    end
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    ack_en = 1'b0; wait_after9 = 1'b1; wait_release = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 wait_irq", wait_irq, 0);
    chk("R1 xmit_mode", xmit_mode, 0);
    chk("R1 addr_selected", addr_selected, 0);
    chk("R1 peer_acked", peer_acked, 0);
    mon_en = 1;

    // Write, wait after ninth clock.
    bus_start();
    send(8'h54, 0, 0, "R2 own address, ack_en=0");
    send(8'h3C, 0, 0, "R6 data ack_en=0");
    ack_en = 1'b1;
    send(8'hA5, 0, 1, "R6 data ack_en=1");
    bus_stop();

    // Foreign address: silent for the whole transfer.
    bus_start();
    send(8'h2B, 0, 1, "R3 foreign address");
    send(8'h0F, 0, 1, "R3 data after miss");
    bus_stop();

    // Extension codes.
    ack_en = 1'b0;
    bus_start();
    send(8'hF0, 0, 0, "R5 ext code ack_en=0");
    bus_stop();
    ack_en = 1'b1;
    bus_start();
    send(8'hF2, 0, 1, "R5 ext code ack_en=1");
    bus_stop();

    // Wait after eighth clock, ack_en set at release.
    wait_after9 = 1'b0; ack_en = 1'b0;
    bus_start();
    send(8'h54, 0, 0, "R2 own address wait8");
    send(8'h81, 0, 1, "R7 data enabled at release");
    send(8'h42, 0, 0, "R7 data refused at release");
    bus_stop();

    // Read transfer: controller acknowledges.
    wait_after9 = 1'b1; ack_en = 1'b1;
    bus_start();
    send(8'h55, 0, 1, "R2 own address read");
    send(8'hFF, 1, 1, "R9 read byte acked");
    send(8'hFF, 0, 1, "R9 read byte nacked");
    bus_stop();

    // Repeated start drops the selection.
    bus_start();
    send(8'h54, 0, 1, "R2 own address before restart");
    bus_start();
    chk("R11 start clears selection", addr_selected, 0);
    send(8'h2B, 0, 1, "R3 foreign after restart");
    bus_stop();

    done = 1;
    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
      $finish;
    end
  end
endmodule